// File: doc/BRIEF.md
# Start-Gated Serial Bit Clock Generator

This block turns a periodic character-time strobe into a serial bit-rate pulse, and runs only while one serial character is in flight. While nothing is being sent or received, both the strobe divider and the per-character bit counter are forced to their cleared state. A character starts in one of two ways. A falling edge on the receive line (the start bit) opens the gate. So does a one-cycle transmit request. Every character's bit timing therefore starts from that character's own start event, not from a free-running phase.

The divider counts only strobes that arrive while the gate is open. In receive mode the first bit pulse comes after half a bit period of strobes, so each later pulse falls near the middle of a received bit. In transmit mode the first pulse comes after a full bit period. The block frames a character of a parameterised length (ten bits by default). After the last bit pulse the gate closes on its own and everything returns to the cleared state. A downstream shifter uses the bit pulse and the bit index to sample or drive data bits.

Top module: `baud_gate_gen`

## Requirements
- R1: After reset, `gate_open` is 0, `bit_tick` is 0 and `bit_index` is 0.
- R2: While `gate_open` is 0, strobes on `char_strobe` produce no `bit_tick`, and `bit_index` stays 0.
- R3: `rx_serial` passes through a two-stage synchronizer. A high-to-low change on it while idle sets `gate_open` on the third rising clock edge after the change.
- R4: In receive mode the first `bit_tick` follows the (DIV_RATIO/2)-th strobe counted from the cycle `gate_open` rises. Each later tick follows every further DIV_RATIO strobes. Each tick appears in the cycle after the clock edge that samples the completing strobe.
- R5: A one-cycle `tx_request` while idle sets `gate_open` on the next clock edge. The first `bit_tick` then follows the DIV_RATIO-th gated strobe, and each later tick follows every further DIV_RATIO strobes.
- R6: `bit_tick` is high for exactly one clock cycle per bit.
- R7: During the k-th tick of a character (counting from 0), `bit_index` equals k. It advances by one in the cycle after each tick and holds otherwise. It never exceeds BITS_PER_CHAR-1 (9 by default).
- R8: One clock cycle after the tick with index BITS_PER_CHAR-1, `gate_open` returns to 0 and `bit_index` returns to 0.
- R9: Falling edges on `rx_serial` while `gate_open` is 1 are ignored: they neither restart nor shift the bit timing.
- R10: `tx_request` while `gate_open` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| char_strobe | input | 1 | One-cycle character-time strobe |
| rx_serial | input | 1 | Asynchronous serial receive line, idle high |
| tx_request | input | 1 | One-cycle request to start transmitting a character |
| bit_tick | output | 1 | One-cycle bit-rate pulse |
| gate_open | output | 1 | High while a character is in progress |
| bit_index | output | 4 | Index of the current bit, 0 to 9 |

## Verification
The assertions assume that `char_strobe` is a single-cycle pulse. With DIV_RATIO of at least four, this guarantees that two bit ticks are never adjacent. They also assume that `rx_serial` stays high long enough for the synchronizer to see it high before it falls. The bench drives each strobe as one high cycle followed by a low cycle. It holds the receive line steady for several strobes around every level change. It raises `tx_request` for a single cycle only. The mid-character disturbances on the receive line and the request input stay clear of the last bit, so the line is back high before the gate closes.

// File: rtl/baud_gate_pkg.sv
package baud_gate_pkg;

   typedef enum logic [1:0] {
      MODE_IDLE = 2'd0,
      MODE_RX   = 2'd1,
      MODE_TX   = 2'd2
   } gate_mode_e;

   function automatic int unsigned half_of(input int unsigned ratio);
      return ratio / 2;
   endfunction

endpackage

// File: rtl/bg_line_sync.sv
module bg_line_sync #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_raw,
   output logic line_fall
);
   localparam int unsigned CHAIN_W = SYNC_STAGES + 1;

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("bg_line_sync: SYNC_STAGES must be at least 2");
   end

   logic [CHAIN_W-1:0] chain_q;

   for (genvar i = 0; i < CHAIN_W; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q[i] <= 1'b1;
            else        chain_q[i] <= line_raw;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q[i] <= 1'b1;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign line_fall = chain_q[CHAIN_W-1] & ~chain_q[CHAIN_W-2];

   assert_fall_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      line_fall |=> !line_fall);

endmodule

// File: rtl/bg_rate_divider.sv
module bg_rate_divider #(
   parameter int unsigned DIV_RATIO   = 8,
   parameter bit          MID_SAMPLE  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic half_first,
   input  logic strobe,
   output logic tick
);
   localparam int unsigned CNT_W  = $clog2(DIV_RATIO);
   localparam int unsigned HALF   = baud_gate_pkg::half_of(DIV_RATIO);
   localparam logic [CNT_W-1:0] LAST_FULL = CNT_W'(DIV_RATIO - 1);
   localparam logic [CNT_W-1:0] LAST_HALF = CNT_W'(HALF - 1);

   if (DIV_RATIO < 4) begin : g_bad_ratio
      $error("bg_rate_divider: DIV_RATIO must be at least 4");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             first_q;
   logic             strobe_g;
   logic [CNT_W-1:0] first_last;
   logic [CNT_W-1:0] last_now;

   assign strobe_g = strobe & run;

   if (MID_SAMPLE) begin : g_mid
      assign first_last = half_first ? LAST_HALF : LAST_FULL;
   end else begin : g_full
      assign first_last = LAST_FULL;
   end

   assign last_now = first_q ? first_last : LAST_FULL;
   assign tick     = strobe_g && (cnt_q == last_now);

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt_q   <= '0;
         first_q <= 1'b1;
      end else if (strobe_g) begin
         if (tick) begin
            cnt_q   <= '0;
            first_q <= 1'b0;
         end else begin
            cnt_q   <= cnt_q + 1'b1;
         end
      end
   end

   assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST_FULL);

   assert_idle_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt_q == '0 && first_q));

endmodule

// File: rtl/bg_bit_framer.sv
module bg_bit_framer #(
   parameter int unsigned BITS_PER_CHAR = 10
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              run,
   input  logic                              tick,
   output logic                              bit_pulse,
   output logic [$clog2(BITS_PER_CHAR)-1:0]  bit_idx,
   output logic                              char_done
);
   localparam int unsigned IDX_W = $clog2(BITS_PER_CHAR);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BITS_PER_CHAR - 1);

   if (BITS_PER_CHAR < 2) begin : g_bad_bits
      $error("bg_bit_framer: BITS_PER_CHAR must be at least 2");
   end

   logic             pulse_q;
   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) pulse_q <= 1'b0;
      else        pulse_q <= tick & run;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !run)  idx_q <= '0;
      else if (pulse_q)    idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
   end

   assign bit_pulse = pulse_q;
   assign bit_idx   = idx_q;
   assign char_done = pulse_q && (idx_q == LAST_IDX);

   assert_index_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= LAST_IDX);

   assert_index_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_q && idx_q != LAST_IDX && run) |=> idx_q == $past(idx_q) + 1'b1);

   assert_index_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!pulse_q && run) |=> $stable(idx_q));

   assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |=> !pulse_q);

endmodule

// File: rtl/baud_gate_gen.sv
module baud_gate_gen #(
   parameter int unsigned DIV_RATIO     = 8,
   parameter int unsigned BITS_PER_CHAR = 10,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter bit          MID_SAMPLE    = 1'b1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             char_strobe,
   input  logic                             rx_serial,
   input  logic                             tx_request,
   output logic                             bit_tick,
   output logic                             gate_open,
   output logic [$clog2(BITS_PER_CHAR)-1:0] bit_index
);
   import baud_gate_pkg::*;

   localparam int unsigned IDX_W = $clog2(BITS_PER_CHAR);

   gate_mode_e       mode_q, mode_d;
   logic             rx_fall;
   logic             div_tick;
   logic             done;
   logic             run;
   logic [IDX_W-1:0] idx;

   bg_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_raw  (rx_serial),
      .line_fall (rx_fall)
   );

   always_comb begin
      mode_d = mode_q;
      unique case (mode_q)
         MODE_IDLE: begin
            if (tx_request)   mode_d = MODE_TX;
            else if (rx_fall) mode_d = MODE_RX;
         end
         MODE_RX, MODE_TX: begin
            if (done) mode_d = MODE_IDLE;
         end
         default: mode_d = MODE_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) mode_q <= MODE_IDLE;
      else        mode_q <= mode_d;
   end

   assign run = (mode_q != MODE_IDLE);

   bg_rate_divider #(.DIV_RATIO(DIV_RATIO), .MID_SAMPLE(MID_SAMPLE)) u_div (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run),
      .half_first (mode_q == MODE_RX),
      .strobe     (char_strobe),
      .tick       (div_tick)
   );

   bg_bit_framer #(.BITS_PER_CHAR(BITS_PER_CHAR)) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .tick      (div_tick),
      .bit_pulse (bit_tick),
      .bit_idx   (idx),
      .char_done (done)
   );

   assign gate_open = run;
   assign bit_index = idx;

   assert_tx_opens_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate_open && tx_request) |=> gate_open);

   assert_tx_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_RX && !done) |=> mode_q == MODE_RX);

   assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_open |-> (!bit_tick && bit_index == '0));

   assert_close_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_tick && bit_index == IDX_W'(BITS_PER_CHAR - 1)) |=> !gate_open);

endmodule

// File: tb/sim_baud_gate_gen.sv
module sim_baud_gate_gen;
   localparam int CLK_PERIOD = 10;
   localparam int N    = 16;
   localparam int HALF = N / 2;
   localparam int BITS = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       char_strobe;
   logic       rx_serial;
   logic       tx_request;
   logic       bit_tick;
   logic       gate_open;
   logic [3:0] bit_index;

   int tests = 0;
   int fails = 0;
   bit done_flag = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   baud_gate_gen #(.DIV_RATIO(N), .BITS_PER_CHAR(BITS)) u0 (
      .clk(clk), .rst_n(rst_n), .char_strobe(char_strobe),
      .rx_serial(rx_serial), .tx_request(tx_request),
      .bit_tick(bit_tick), .gate_open(gate_open), .bit_index(bit_index)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic test_reset;
      rst_n = 1'b0; char_strobe = 1'b0; rx_serial = 1'b1; tx_request = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(gate_open == 1'b0, "R1 gate", int'(gate_open), 0);
      chk(bit_tick == 1'b0, "R1 tick", int'(bit_tick), 0);
      chk(bit_index == 4'd0, "R1 index", int'(bit_index), 0);
   endtask

   task automatic test_idle_strobes;
      int seen = 0;
      for (int i = 0; i < 3 * N; i++) begin
         char_strobe = 1'b1;
         @(negedge clk);
         char_strobe = 1'b0;
         if (bit_tick || gate_open || bit_index != 0) seen++;
         @(negedge clk);
         if (bit_tick || gate_open || bit_index != 0) seen++;
      end
      chk(seen == 0, "R2 idle strobes", seen, 0);
   endtask

   // Drives strobes through one character and checks tick timing and index.
   task automatic run_char(input int first, input bit disturb, input string tag);
      int pulse_no = 0;
      int total = first + (BITS - 1) * N;
      for (int s = 1; s <= total; s++) begin
         char_strobe = 1'b1;
         if (disturb && s == first + N + 2)     rx_serial  = 1'b1;
         if (disturb && s == first + N + 5)     rx_serial  = 1'b0; // R9
         if (disturb && s == first + 2 * N + 3) rx_serial  = 1'b1;
         if (disturb && s == first + 3 * N)     tx_request = 1'b1; // R10
         @(negedge clk);
         char_strobe = 1'b0;
         tx_request  = 1'b0;
         if (s == first + pulse_no * N) begin
            chk(bit_tick == 1'b1, {tag, " tick due"}, int'(bit_tick), 1);
            chk(bit_index == 4'(pulse_no), "R7 index at tick", int'(bit_index), pulse_no);
            chk(gate_open == 1'b1, "R9 gate held", int'(gate_open), 1);
            pulse_no++;
            @(negedge clk);
            chk(bit_tick == 1'b0, "R6 single cycle", int'(bit_tick), 0);
         end else begin
            chk(bit_tick == 1'b0, {tag, " no early tick"}, int'(bit_tick), 0);
            @(negedge clk);
         end
      end
      chk(pulse_no == BITS, {tag, " tick count"}, pulse_no, BITS);
      chk(gate_open == 1'b0, "R8 gate closes", int'(gate_open), 0);
      chk(bit_index == 4'd0, "R8 index cleared", int'(bit_index), 0);
   endtask

   task automatic test_rx_char(input bit disturb);
      rx_serial = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk(gate_open == 1'b0, "R3 not yet open", int'(gate_open), 0);
      @(negedge clk);
      chk(gate_open == 1'b1, "R3 open on third edge", int'(gate_open), 1);
      run_char(HALF, disturb, "R4");
      rx_serial = 1'b1;
      repeat (6) @(negedge clk);
      chk(gate_open == 1'b0, "R8 stays idle", int'(gate_open), 0);
   endtask

   task automatic test_tx_char;
      tx_request = 1'b1;
      @(negedge clk);
      tx_request = 1'b0;
      chk(gate_open == 1'b1, "R5 open next edge", int'(gate_open), 1);
      run_char(N, 1'b0, "R5");
   endtask

   initial begin
      test_reset();
      test_idle_strobes();
      test_rx_char(1'b0);
      test_tx_char();
      test_rx_char(1'b1);
      test_tx_char();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done_flag) begin
         done_flag = 1'b1;
         tests++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule